// File: doc/BRIEF.md
# One-shot/periodic microsecond timer

A programmable down-counting timer that advances once per external tick strobe (one pulse per microsecond in normal use). Software programs it with a single word write that sets the enable, selects one-shot or repeating operation and supplies the reload value. To get a period of N ticks, software writes N-1. The counter reaches zero after N-1 ticks and expires on the tick after that, so each period is exactly N ticks.

At expiry the timer raises an active-high, level-sensitive interrupt. The interrupt stays high until software writes a one to the clear bit of the status register. In repeating mode the count is reloaded and keeps running. In one-shot mode the enable bit clears itself. Writing zero to the trigger register stops the timer. A new trigger write restarts the count from the new value at once. The status register reads back the live down-count and the pending flag.

Top module: `utick_timer`

## Requirements
- R1: After reset, irq is low and both registers read as zero.
- R2: The trigger register is at word offset 0x0 (addr[2]=0). In a write to it:
  - bit 31 is the enable;
  - bit 30 selects repeating mode when 1 and one-shot mode when 0;
  - bits 28:0 hold the reload value.

  A read returns these same fields. Bit 29 reads as zero.
- R3: In one-shot mode with reload value V, irq stays low through V ticks and is high after tick V+1. After expiry, the enable bit reads 0 and the count reads 0.
- R4: In repeating mode with reload value V, irq rises every V+1 ticks. At each expiry the count reloads to V and the enable bit stays 1.
- R5: Once irq is high, it stays high until a write to offset 0x4 with bit 30 set. A write there with bit 30 clear leaves irq unchanged.
- R6: A read of the status register at offset 0x4 returns the pending flag in bit 30 and the current down-count in bits 28:0. All other bits read as zero.
- R7: Writing zero to the trigger register stops the timer. Further ticks then cause no interrupt and leave the count at 0.
- R8: A trigger write loads the new value into the count in the same cycle. It does not clear an interrupt that is already pending.
- R9: The count does not change while the timer is disabled, or in cycles with no tick.
- R10: When an expiry and a clear write happen in the same cycle, the interrupt is left pending.
- R11: When a trigger write and a tick happen in the same cycle, the count takes the written value and the tick is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle tick strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address within the timer window; bit 2 selects the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr; combinational |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench builds the timer with its default parameters: a 29-bit count and a 3-bit address. With these values the full-width reload value 0x1fffffff can be written and read back, so the field positions of both registers are checked at their real extent. Expiry timing uses small reload values, which make one-shot and repeating expiry reachable within a short run, as well as the zero-value case that expires on the first tick. Same-cycle collisions of tick, clear and trigger writes are driven on purpose.

// File: rtl/utmr_pkg.sv
package utmr_pkg;
    localparam int DATA_W     = 32;
    localparam int CNT_W_DEF  = 29;
    localparam int EN_BIT     = 31;
    localparam int MODE_BIT   = 30;
    localparam int PEND_BIT   = 30;
    localparam int SEL_BIT    = 2;

    typedef enum logic { REG_TRIG = 1'b0, REG_STAT = 1'b1 } reg_sel_e;

    typedef struct packed {
        logic enable;
        logic periodic;
    } tmr_mode_t;

    function automatic reg_sel_e decode_sel(input logic sel_bit);
        return sel_bit ? REG_STAT : REG_TRIG;
    endfunction
endpackage

// File: rtl/utmr_counter.sv
module utmr_counter
    import utmr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  tmr_mode_t        mode,
    input  logic [CNT_W-1:0] reload_value,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic step;
    logic at_zero;

    assign step    = mode.enable & tick & ~load;
    assign at_zero = (count == '0);
    assign expire  = step & at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_value;
        end else if (step) begin
            if (at_zero)
                count <= mode.periodic ? reload_value : '0;
            else
                count <= count - 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        mode.enable |-> (count <= reload_value)); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!load && (!mode.enable || !tick)) |=> $stable(count)); // R9

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_value))); // R11
endmodule

// File: rtl/utmr_pending.sv
module utmr_pending (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (set)
            pending <= 1'b1;
        else if (clr)
            pending <= 1'b0;
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        set |=> pending); // R10

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pending && !clr) |=> pending); // R5

    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pending); // R5
endmodule

// File: rtl/utmr_regs.sv
module utmr_regs
    import utmr_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              expire,
    input  logic [CNT_W-1:0]  count,
    input  logic              pending,
    output tmr_mode_t         mode,
    output logic [CNT_W-1:0]  reload_value,
    output logic              load,
    output logic [CNT_W-1:0]  load_value,
    output logic              clr,
    output logic [DATA_W-1:0] rd_data
);
    reg_sel_e sel;

    assign sel        = decode_sel(addr[SEL_BIT]);
    assign load       = wr_en && (sel == REG_TRIG);
    assign load_value = wr_data[CNT_W-1:0];
    assign clr        = wr_en && (sel == REG_STAT) && wr_data[PEND_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= '0;
            reload_value <= '0;
        end else if (load) begin
            mode.enable   <= wr_data[EN_BIT];
            mode.periodic <= wr_data[MODE_BIT];
            reload_value  <= wr_data[CNT_W-1:0];
        end else if (expire && !mode.periodic) begin
            mode.enable <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (sel == REG_TRIG) begin
            rd_data[EN_BIT]      = mode.enable;
            rd_data[MODE_BIT]    = mode.periodic;
            rd_data[CNT_W-1:0]   = reload_value;
        end else begin
            rd_data[PEND_BIT]    = pending;
            rd_data[CNT_W-1:0]   = count;
        end
    end

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (expire && !mode.periodic && !load) |=> !mode.enable); // R3

    AST_PERIODIC_KEEP: assert property (@(posedge clk) disable iff (rst)
        (expire && mode.periodic && !load) |=> mode.enable); // R4
endmodule

// File: rtl/utick_timer.sv
module utick_timer
    import utmr_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              irq
);
    tmr_mode_t        mode;
    logic [CNT_W-1:0] reload_value;
    logic [CNT_W-1:0] load_value;
    logic [CNT_W-1:0] count;
    logic             load;
    logic             clr;
    logic             expire;
    logic             pending;

    utmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .expire       (expire),
        .count        (count),
        .pending      (pending),
        .mode         (mode),
        .reload_value (reload_value),
        .load         (load),
        .load_value   (load_value),
        .clr          (clr),
        .rd_data      (rd_data)
    );

    utmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .load         (load),
        .load_value   (load_value),
        .mode         (mode),
        .reload_value (reload_value),
        .count        (count),
        .expire       (expire)
    );

    utmr_pending u_pend (
        .clk     (clk),
        .rst     (rst),
        .set     (expire),
        .clr     (clr),
        .pending (pending)
    );

    assign irq = pending;

    initial begin
        AST_CNT_FITS: assert (CNT_W >= 1 && CNT_W <= 29); // R2
    end
endmodule

// File: tb/sim_utick_timer.sv
module sim_utick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] A_TRIG = 3'd0;
    localparam logic [2:0] A_STAT = 3'd4;
    localparam int NVEC = 5;
    localparam logic [31:0] VEC [NVEC] = '{32'd0, 32'd1, 32'd2, 32'd5, 32'd12};

    always #4 clk = ~clk;

    utick_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en = w; addr = a; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, A_TRIG, 32'd0, 1'b1);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    logic [31:0] r;

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(A_TRIG, r); chk("R1 trig", r, 32'd0);
        rd(A_STAT, r); chk("R1 stat", r, 32'd0);

        // R3 table walk: one-shot expiry after V+1 ticks
        for (int k = 0; k < NVEC; k++) begin
            wr(A_TRIG, 32'h8000_0000 | VEC[k]);
            ticks(VEC[k]);
            chk("R3 not yet", {31'd0, irq}, 32'd0);
            rd(A_STAT, r); chk("R6 count zero", r, 32'd0);
            ticks(1);
            chk("R3 expired", {31'd0, irq}, 32'd1);
            rd(A_TRIG, r); chk("R3 en cleared", r, VEC[k]);
            rd(A_STAT, r); chk("R6 pending", r, 32'h4000_0000);
            wr(A_STAT, 32'h4000_0000);
            chk("R5 cleared", {31'd0, irq}, 32'd0);
        end

        // R2 full-width field readback
        wr(A_TRIG, 32'hFFFF_FFFF);
        rd(A_TRIG, r); chk("R2 readback", r, 32'hDFFF_FFFF);
        rd(A_STAT, r); chk("R6 loaded count", r, 32'h1FFF_FFFF);
        wr(A_TRIG, 32'h0);

        // R4 periodic reload
        wr(A_TRIG, 32'hC000_0003);
        ticks(2);
        rd(A_STAT, r); chk("R6 midcount", r, 32'd1);
        ticks(2);
        chk("R4 first expiry", {31'd0, irq}, 32'd1);
        rd(A_STAT, r); chk("R4 reloaded", r, 32'h4000_0003);
        rd(A_TRIG, r); chk("R4 en kept", r, 32'hC000_0003);
        // R5 write with bit30 clear leaves irq
        wr(A_STAT, 32'hBFFF_FFFF);
        chk("R5 no clear", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'h4000_0000);
        ticks(3);
        chk("R4 low before second", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R4 second expiry", {31'd0, irq}, 32'd1);

        // R8 rewrite keeps pending, loads at once
        wr(A_TRIG, 32'h8000_0007);
        chk("R8 pending kept", {31'd0, irq}, 32'd1);
        rd(A_STAT, r); chk("R8 new count", r, 32'h4000_0007);
        wr(A_STAT, 32'h4000_0000);
        ticks(7);
        chk("R8 not yet", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R8 expiry", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'h4000_0000);

        // R7 writing zero stops
        wr(A_TRIG, 32'hC000_0002);
        ticks(1);
        wr(A_TRIG, 32'h0);
        ticks(10);
        chk("R7 no irq", {31'd0, irq}, 32'd0);
        rd(A_STAT, r); chk("R7 count", r, 32'd0);
        rd(A_TRIG, r); chk("R7 trig", r, 32'd0);

        // R9 disabled / no tick
        wr(A_TRIG, 32'h0000_0004);
        ticks(6);
        rd(A_STAT, r); chk("R9 disabled stable", r, 32'd4);
        wr(A_TRIG, 32'h8000_0004);
        repeat (5) @(negedge clk);
        rd(A_STAT, r); chk("R9 no tick stable", r, 32'd4);

        // R11 write and tick together
        cyc(1'b1, A_TRIG, 32'h8000_0005, 1'b1);
        rd(A_STAT, r); chk("R11 write wins", r, 32'd5);

        // R10 expiry and clear together
        wr(A_TRIG, 32'h8000_0000);
        cyc(1'b1, A_STAT, 32'h4000_0000, 1'b1);
        chk("R10 set wins", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'h4000_0000);
        chk("R10 later clear", {31'd0, irq}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule